// File: doc/BRIEF.md
# SCL Timing Generator

This block produces the clock-line timing for a two-wire serial master. A functional clock is first divided by a programmable prescaler, giving an internal tick. The tick then drives a small phase machine that holds the clock line low for one programmed count and releases it for another. The low count and the high count each carry a fixed hardware offset.

Each of the two 16-bit timing words carries two counts. The lower byte applies at standard and fast speed. The upper byte applies to the high-speed part of a transfer. In a high-speed transfer the master-code phase still runs at fast timing, so the upper bytes are used only when high-speed mode is selected and the caller reports that the master-code phase is complete.

The block does not drive the line directly. It outputs a pull-low request, and it watches a stretch input that shows a slave holding the line low. The high count does not start until that input clears. One-cycle strobes mark each falling and rising edge, so byte and bit sequencing logic outside the block can follow the bus.

Top module: `scl_timer_top`

## Requirements
- R1: The internal tick occurs once every (psc + 1) functional-clock cycles. It restarts at the start of each low or high period, so every period is a whole number of ticks.
- R2: The low period lasts (L + 7) × (psc + 1) functional-clock cycles. It is measured as the cycles in which `scl_pull_low` is 1, starting with the cycle of `fall_pulse`. L is the selected low count.
- R3: The high period lasts (H + 5) × (psc + 1) cycles. It is counted from the cycle of `rise_pulse` up to, but not including, the next `fall_pulse`. H is the selected high count.
- R4: A selected count is bits [7:0] of its timing word, except when `hs_mode` = 1 and `mc_done` = 1, in which case it is bits [15:8]. When `hs_mode` = 0, `mc_done` has no effect.
- R5: The word bytes, `hs_mode` and `mc_done` are sampled once, at the start of each period. A change that arrives during a period takes effect from the next period.
- R6: When the low period ends, the line is released. The high count starts only after `stretch_in` is sampled 0. `rise_pulse` appears K + 1 cycles after release, where K is the number of cycles `stretch_in` is held high from the first released cycle.
- R7: One cycle after `en` is sampled 0, all outputs are 0 and the counters are cleared. One cycle after `en` is sampled 1 again, a full new low period begins, marked by `fall_pulse`.
- R8: Each strobe is one cycle wide. `fall_pulse` occurs exactly in the first cycle of `scl_pull_low`. The two strobes never occur in the same cycle.
- R9: While `rst` is high, and afterwards while `en` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 releases the line and clears the counters |
| psc | input | 8 | Prescaler value; tick period is psc + 1 cycles |
| lo_word | input | 16 | Low-time word: [7:0] fast count, [15:8] high-speed count |
| hi_word | input | 16 | High-time word: [7:0] fast count, [15:8] high-speed count |
| hs_mode | input | 1 | Selects high-speed operation |
| mc_done | input | 1 | Master-code phase finished; enables the upper bytes in high-speed mode |
| stretch_in | input | 1 | Clock line seen held low by a slave |
| scl_pull_low | output | 1 | Request to drive the clock line low |
| rise_pulse | output | 1 | One-cycle strobe at the start of the high period |
| fall_pulse | output | 1 | One-cycle strobe at the start of the low period |

## Verification
Two events can fall in the same cycle: the boundary at which a period samples its count, and a change to the count inputs. The bench provokes this by flipping `mc_done` or rewriting a timing word in the very cycle that `fall_pulse` is visible. It then judges the result by measuring the current low period at its old length and the following high and low periods at their new lengths. A second coincidence is stretch release against the end of the low count. For this the bench raises `stretch_in` in the first released cycle and checks that the rise strobe slides by exactly the stretched cycles.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    // Fixed hardware offsets added to the programmed counts
    localparam int LOW_OFS  = 7;
    localparam int HIGH_OFS = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_REL  = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    assign tick = (pcnt == psc);

    always_ff @(posedge clk) begin
        if (rst || !en || restart) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PSC_W'(1);
        end
    end
endmodule

// File: rtl/scl_phase_select.sv
module scl_phase_select
    import scl_timing_pkg::*;
#(
    parameter int TIME_W = 16,
    localparam int HALF_W = TIME_W / 2,
    localparam int LEN_W  = HALF_W + 1
) (
    input  logic [TIME_W-1:0] lo_word,
    input  logic [TIME_W-1:0] hi_word,
    input  logic              hs_mode,
    input  logic              mc_done,
    output logic [LEN_W-1:0]  lo_len,
    output logic [LEN_W-1:0]  hi_len
);
    logic                use_hs;
    logic [TIME_W-1:0]   words [2];
    logic [LEN_W-1:0]    lens  [2];

    assign use_hs   = hs_mode & mc_done;
    assign words[0] = lo_word;
    assign words[1] = hi_word;

    for (genvar g = 0; g < 2; g++) begin : g_pick
        localparam int OFS = (g == 0) ? LOW_OFS : HIGH_OFS;
        logic [HALF_W-1:0] sel;
        assign sel     = use_hs ? words[g][TIME_W-1:HALF_W] : words[g][HALF_W-1:0];
        assign lens[g] = {1'b0, sel} + LEN_W'(OFS);
    end

    assign lo_len = lens[0];
    assign hi_len = lens[1];
endmodule

// File: rtl/scl_period_fsm.sv
module scl_period_fsm
    import scl_timing_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             stretch_in,
    input  logic [LEN_W-1:0] lo_len,
    input  logic [LEN_W-1:0] hi_len,
    output logic             restart,
    output logic             scl_pull_low,
    output logic             rise_pulse,
    output logic             fall_pulse
);
    scl_phase_e       state, nxt;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] tgt;
    logic             done;
    logic             enter_low, enter_high;

    assign done = tick && (cnt == tgt - LEN_W'(1));

    always_comb begin
        nxt = state;
        case (state)
            PH_IDLE: if (en)          nxt = PH_LOW;
            PH_LOW:  if (done)        nxt = PH_REL;
            PH_REL:  if (!stretch_in) nxt = PH_HIGH;
            PH_HIGH: if (done)        nxt = PH_LOW;
            default:                  nxt = PH_IDLE;
        endcase
        if (!en) nxt = PH_IDLE;
    end

    assign restart    = (nxt != state);
    assign enter_low  = (nxt == PH_LOW)  && (state != PH_LOW);
    assign enter_high = (nxt == PH_HIGH) && (state != PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PH_IDLE;
            cnt        <= '0;
            tgt        <= '0;
            fall_pulse <= 1'b0;
            rise_pulse <= 1'b0;
        end else begin
            state      <= nxt;
            fall_pulse <= enter_low;
            rise_pulse <= enter_high;
            if (restart)   cnt <= '0;
            else if (tick) cnt <= cnt + LEN_W'(1);
            if (enter_low)       tgt <= lo_len;
            else if (enter_high) tgt <= hi_len;
        end
    end

    assign scl_pull_low = (state == PH_LOW);
endmodule

// File: rtl/scl_timer_top.sv
module scl_timer_top #(
    parameter int PSC_W  = 8,
    parameter int TIME_W = 16,
    localparam int LEN_W = TIME_W / 2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PSC_W-1:0]  psc,
    input  logic [TIME_W-1:0] lo_word,
    input  logic [TIME_W-1:0] hi_word,
    input  logic              hs_mode,
    input  logic              mc_done,
    input  logic              stretch_in,
    output logic              scl_pull_low,
    output logic              rise_pulse,
    output logic              fall_pulse
);
    logic             tick;
    logic             restart;
    logic [LEN_W-1:0] lo_len, hi_len;

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .restart (restart),
        .psc     (psc),
        .tick    (tick)
    );

    scl_phase_select #(.TIME_W(TIME_W)) u_sel (
        .lo_word (lo_word),
        .hi_word (hi_word),
        .hs_mode (hs_mode),
        .mc_done (mc_done),
        .lo_len  (lo_len),
        .hi_len  (hi_len)
    );

    scl_period_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .tick         (tick),
        .stretch_in   (stretch_in),
        .lo_len       (lo_len),
        .hi_len       (hi_len),
        .restart      (restart),
        .scl_pull_low (scl_pull_low),
        .rise_pulse   (rise_pulse),
        .fall_pulse   (fall_pulse)
    );
endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk
    import scl_timing_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic en,
    input logic stretch_in,
    input logic scl_pull_low,
    input logic rise_pulse,
    input logic fall_pulse
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst || !scl_pull_low) run <= '0;
        else if (run != 16'hFFFF) run <= run + 16'd1;
    end

    p_fall_one_r8: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |=> !fall_pulse);

    p_rise_one_r8: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(fall_pulse && rise_pulse));

    p_low_starts_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull_low) |-> fall_pulse);

    p_fall_low_r8: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |-> scl_pull_low);

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_pull_low && !fall_pulse && !rise_pulse));

    p_stretch_gate_r6: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |-> (!$past(stretch_in) && !scl_pull_low));

    p_low_min_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_pull_low) && $past(en)) |-> (run >= 16'(LOW_OFS)));
endmodule

bind scl_timer_top scl_timer_chk u_chk (.*);

// File: tb/sim_scl_timer_top.sv
module sim_scl_timer_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  psc = '0;
    logic [15:0] lo_word = '0;
    logic [15:0] hi_word = '0;
    logic        hs_mode = 1'b0;
    logic        mc_done = 1'b0;
    logic        stretch_in = 1'b0;
    logic        scl_pull_low, rise_pulse, fall_pulse;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scl_timer_top u0 (
        .clk(clk), .rst(rst), .en(en), .psc(psc),
        .lo_word(lo_word), .hi_word(hi_word),
        .hs_mode(hs_mode), .mc_done(mc_done), .stretch_in(stretch_in),
        .scl_pull_low(scl_pull_low), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [15:0] w, input bit hs, input bit mc,
                                   input int ofs, input int p);
        int b;
        b = (hs && mc) ? int'(w[15:8]) : int'(w[7:0]);
        return (b + ofs) * (p + 1);
    endfunction

    // Measures one low period, the release gap and one high period; ends on the next fall strobe
    task automatic measure(input int exp_lo, input int exp_hi, input int k, input string req);
        int n = 0, nf = 0, r = 0, h = 0, nr = 0;
        while (!fall_pulse) @(negedge clk);
        while (scl_pull_low) begin
            n++;
            if (fall_pulse) nf++;
            @(negedge clk);
        end
        chk(n == exp_lo, {req, " R2 low period"}, n, exp_lo);
        chk(nf == 1, "R8 fall strobe width", nf, 1);
        if (k > 0) begin
            stretch_in = 1'b1;
            repeat (k) @(negedge clk);
            stretch_in = 1'b0;
            r = k;
        end
        while (!rise_pulse) begin
            r++;
            @(negedge clk);
        end
        chk(r == k + 1, "R6 release to rise", r, k + 1);
        while (!fall_pulse) begin
            h++;
            if (rise_pulse) nr++;
            @(negedge clk);
        end
        chk(h == exp_hi, {req, " R3 high period"}, h, exp_hi);
        chk(nr == 1, "R8 rise strobe width", nr, 1);
    endtask

    task automatic restart_cfg(input int p, input logic [15:0] lw, input logic [15:0] hw,
                               input bit hs, input bit mc);
        en = 1'b0;
        @(negedge clk);
        chk(!scl_pull_low && !fall_pulse && !rise_pulse, "R7 outputs quiet when disabled",
            int'(scl_pull_low), 0);
        psc = 8'(p); lo_word = lw; hi_word = hw; hs_mode = hs; mc_done = mc;
        en = 1'b1;
        @(negedge clk);
        chk(fall_pulse && scl_pull_low, "R7 low starts one cycle after enable",
            int'(fall_pulse), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset state and idle state
        repeat (3) @(negedge clk);
        chk(!scl_pull_low && !rise_pulse && !fall_pulse, "R9 outputs during reset",
            int'(scl_pull_low), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!scl_pull_low && !rise_pulse && !fall_pulse, "R9 outputs idle with en low",
            int'(scl_pull_low) + int'(fall_pulse), 0);

        // R1 R2 R3: sweep of prescaler and fast counts, upper bytes must be ignored (R4)
        for (int p = 0; p < 3; p++) begin
            for (int lb = 0; lb < 4; lb++) begin
                for (int hb = 0; hb < 4; hb++) begin
                    restart_cfg(p, {8'h3C, 8'(lb)}, {8'h21, 8'(hb)}, 1'b0, 1'b1);
                    measure((lb + 7) * (p + 1), (hb + 5) * (p + 1), 0, "R1");
                end
            end
        end

        // R4: byte selection in high-speed mode
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 3; i++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [15:0] lw, hw;
                    lw = {8'(2 + i), 8'(i + 1)};
                    hw = {8'(1 + i), 8'd3};
                    restart_cfg(p, lw, hw, 1'b1, 1'(m));
                    measure(exp_len(lw, 1'b1, 1'(m), 7, p), exp_len(hw, 1'b1, 1'(m), 5, p),
                            0, "R4");
                end
            end
        end

        // R5 + R4: mc_done flips in the same cycle as the fall strobe
        restart_cfg(1, 16'h0602, 16'h0401, 1'b1, 1'b0);
        mc_done = 1'b1;
        measure(exp_len(16'h0602, 1'b1, 1'b0, 7, 1), exp_len(16'h0401, 1'b1, 1'b1, 5, 1),
                0, "R5 switch");
        measure(exp_len(16'h0602, 1'b1, 1'b1, 7, 1), exp_len(16'h0401, 1'b1, 1'b1, 5, 1),
                0, "R5 after");

        // R5: low word rewritten during the low period
        restart_cfg(0, 16'h0002, 16'h0002, 1'b0, 1'b0);
        lo_word = 16'h0009;
        measure(9, 7, 0, "R5 old low");
        measure(16, 7, 0, "R5 new low");

        // R6: stretch of several lengths
        for (int k = 1; k < 12; k += 4) begin
            restart_cfg(1, 16'h0001, 16'h0002, 1'b0, 1'b0);
            measure(16, 14, k, "R6");
        end

        // R7: disable in the middle of a low period, then full restart
        restart_cfg(0, 16'h0005, 16'h0000, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!scl_pull_low && !fall_pulse && !rise_pulse, "R7 release after disable",
            int'(scl_pull_low), 0);
        repeat (5) begin
            @(negedge clk);
            chk(!scl_pull_low && !rise_pulse && !fall_pulse, "R7 stays quiet", int'(scl_pull_low), 0);
        end
        en = 1'b1;
        @(negedge clk);
        chk(fall_pulse, "R7 fall strobe after re-enable", int'(fall_pulse), 1);
        measure(12, 5, 0, "R7 full low");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule